// File: doc/BRIEF.md
# Command-Set Flash Bank Programmer

This block is a hardware sequencer that erases or programs one bank of a byte-wide parallel flash device. The device is controlled through command bytes written to it and reports progress through a status byte. A host pulses `start` with `op` choosing erase (0) or program (1). For a program run, the block pulls source bytes one at a time over a ready/valid stream. It presents the byte index it wants on `src_addr` and takes `src_data` on a cycle where both `src_ready` and `src_valid` are high.

Each run has three phases. First the block issues the command writes. Then it polls the status byte until the device reports ready. After that it returns the device to array-read mode and reads back the whole bank. The read-back is compared with 0xFF after an erase, or with the source byte for each address after a program. When the run ends, the block pulses `done` and holds three result outputs until the next start: a poll timeout flag, a verify-fail flag, and the captured device error bits.

The bank size, the poll limit and the setup wait are parameters. The setup wait is a count of clock cycles, and at the default 125 cycles it gives the 1 µs the device needs at 125 MHz.

Top module: `flash_bank_seq`

## Requirements
- R1: An erase run opens with two writes to bank offset 0: 0x20, then 0xD0.
- R2: Every status read (read strobe at offset 0 during a poll) is preceded by a write of 0x70 to offset 0. Polling ends on the first status byte with bit 7 set.
- R3: A program run handles the bank bytes in ascending address order. For each byte it writes 0x40 to the target address, waits exactly SETUP_WAIT idle bus cycles, writes the source byte to the same address, then polls.
- R4: Once polling of the last operation ends, whether by ready or by timeout, the block writes 0x50 and then 0xFF to offset 0.
- R5: If POLL_LIMIT consecutive status reads all show bit 7 clear, `timeout` is set. A ready status on the POLL_LIMIT-th read does not set it.
- R6: A timeout during a program run stops the byte loop. No later byte receives a 0x40 or data write.
- R7: After the recovery writes, the block reads every address of the bank once in array mode. After an erase, `verify_fail` is set if any read byte differs from 0xFF. The verify runs even after a timeout.
- R8: After a program, each address read back is compared with the source byte fetched again for that address through the stream. `verify_fail` is set on any difference.
- R9: `err_status` is the OR of status bits 5:3 from every ready status byte seen in the run. Its bit 0 holds status bit 3.
- R10: `busy` is high from the cycle after an accepted start until `done`. `done` is a single-cycle pulse with `busy` low. The result outputs hold until the next start, which clears them.
- R11: The write and read strobes are never high in the same cycle.
- R12: After reset the block is idle with all outputs and strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted when idle |
| op | input | 1 | Operation: 0 erase, 1 program |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| timeout | output | 1 | A status poll exhausted its limit |
| verify_fail | output | 1 | Read-back mismatch found |
| err_status | output | 3 | Captured device error bits 5:3 |
| src_addr | output | ADDR_W | Index of the requested source byte |
| src_valid | input | 1 | Source byte present |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Block is waiting for a source byte |
| fl_addr | output | ADDR_W | Flash byte address within the bank |
| fl_wdata | output | 8 | Flash write data or command |
| fl_rdata | input | 8 | Flash read data, valid one cycle after the read strobe |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |

## Verification
The bench drives a behavioural flash model that logs every bus write and counts status and array reads. Each run is compared against the write sequence predicted for it.

The poll limit is probed from both sides. A device that turns ready exactly on the last permitted read must not raise a timeout, and one that never turns ready must produce exactly POLL_LIMIT status reads. An off-by-one counter fails one of these two runs.

A bit that cannot be erased, and a program pass over a bank that was not erased, must both raise the fail flag. A rewrite of identical data must not. A verify that skips addresses or compares against the wrong expected value would get at least one of these wrong.

A stuck device during programming must leave exactly one byte's command pair in the log. Error bits must appear in one run and be gone in the next.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   // Device command bytes
   localparam logic [7:0] FC_ERASE_ARM = 8'h20;
   localparam logic [7:0] FC_ERASE_GO  = 8'hD0;
   localparam logic [7:0] FC_PROG_ARM  = 8'h40;
   localparam logic [7:0] FC_STAT_CLR  = 8'h50;
   localparam logic [7:0] FC_STAT_RD   = 8'h70;
   localparam logic [7:0] FC_READ_MODE = 8'hFF;
   localparam logic [7:0] ERASED_BYTE  = 8'hFF;

   // Status byte layout
   localparam int RDY_BIT = 7;
   localparam int ERR_HI  = 5;
   localparam int ERR_LO  = 3;

   typedef enum logic [3:0] {
      S_IDLE,
      S_ERA_ARM,
      S_ERA_GO,
      S_PRG_FETCH,
      S_PRG_ARM,
      S_PRG_WAIT,
      S_PRG_DATA,
      S_POLL_CMD,
      S_POLL_RD,
      S_POLL_SMP,
      S_FIN_CLR,
      S_FIN_RST,
      S_VER_FETCH,
      S_VER_RD,
      S_VER_SMP,
      S_DONE
   } seq_state_e;

   // One bus access per state
   typedef struct packed {
      logic       we;
      logic       re;
      logic       at_base;
      logic       use_byte;
      logic [7:0] wdata;
   } bus_op_t;

endpackage

// File: rtl/flash_bank_seq_poll.sv
module flash_bank_seq_poll #(
   parameter int unsigned LIMIT = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic miss,
   output logic last
);
   localparam int unsigned CW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("flash_bank_seq_poll: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] miss_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         miss_cnt <= '0;
      else if (clr)
         miss_cnt <= '0;
      else if (miss)
         miss_cnt <= miss_cnt + 1'b1;
   end

   assign last = (miss_cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/flash_bank_seq_wait.sv
module flash_bank_seq_wait #(
   parameter int unsigned CYCLES = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   generate
      if (CYCLES == 0) begin : g_none
         logic unused_wait;
         assign unused_wait = ^{clk, rst_n, load};
         assign expired     = 1'b1;
      end else begin : g_cnt
         localparam int unsigned WW = $clog2(CYCLES + 1);
         logic [WW-1:0] left;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               left <= '0;
            else if (load)
               left <= WW'(CYCLES);
            else if (left != '0)
               left <= left - 1'b1;
         end

         // Waiting state lasts CYCLES cycles: left runs CYCLES..1
         assign expired = (left <= WW'(1));
      end
   endgenerate

endmodule

// File: rtl/flash_bank_seq.sv
module flash_bank_seq
   import flash_seq_pkg::*;
#(
   parameter int unsigned ADDR_W     = 13,
   parameter int unsigned POLL_LIMIT = 1000000,
   parameter int unsigned SETUP_WAIT = 125
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op,
   output logic              busy,
   output logic              done,
   output logic              timeout,
   output logic              verify_fail,
   output logic [2:0]        err_status,
   output logic [ADDR_W-1:0] src_addr,
   input  logic              src_valid,
   input  logic [7:0]        src_data,
   output logic              src_ready,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [7:0]        fl_wdata,
   input  logic [7:0]        fl_rdata,
   output logic              fl_we,
   output logic              fl_re
);
   localparam logic [ADDR_W-1:0] LAST_IDX = '1;

   generate
      if (ADDR_W < 1 || ADDR_W > 24) begin : g_bad_addr
         $error("flash_bank_seq: ADDR_W out of range 1..24");
      end
   endgenerate

   seq_state_e        state;
   logic              is_prog;
   logic [ADDR_W-1:0] idx;
   logic [7:0]        byte_q;
   logic              tmo_q;
   logic              vfail_q;
   logic [2:0]        err_q;

   logic    poll_clr, poll_miss, poll_last;
   logic    wait_load, wait_done;
   logic    stat_ready;
   logic    take_src;
   logic    last_byte;
   logic [7:0] expect_byte;
   bus_op_t bus;

   flash_bank_seq_poll #(.LIMIT(POLL_LIMIT)) u_poll (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (poll_clr),
      .miss  (poll_miss),
      .last  (poll_last)
   );

   flash_bank_seq_wait #(.CYCLES(SETUP_WAIT)) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (wait_load),
      .expired (wait_done)
   );

   assign stat_ready  = fl_rdata[RDY_BIT];
   assign last_byte   = (idx == LAST_IDX);
   assign take_src    = src_ready && src_valid;
   assign expect_byte = is_prog ? byte_q : ERASED_BYTE;
   assign poll_clr    = (state == S_ERA_GO) || (state == S_PRG_DATA);
   assign poll_miss   = (state == S_POLL_SMP) && !stat_ready;
   assign wait_load   = (state == S_PRG_ARM);

   // Sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         is_prog <= 1'b0;
         idx     <= '0;
         byte_q  <= '0;
         tmo_q   <= 1'b0;
         vfail_q <= 1'b0;
         err_q   <= '0;
      end else begin
         unique case (state)
            S_IDLE: begin
               if (start) begin
                  is_prog <= op;
                  idx     <= '0;
                  tmo_q   <= 1'b0;
                  vfail_q <= 1'b0;
                  err_q   <= '0;
                  state   <= op ? S_PRG_FETCH : S_ERA_ARM;
               end
            end
            S_ERA_ARM: state <= S_ERA_GO;
            S_ERA_GO:  state <= S_POLL_CMD;
            S_PRG_FETCH: begin
               if (take_src) begin
                  byte_q <= src_data;
                  state  <= S_PRG_ARM;
               end
            end
            S_PRG_ARM:  state <= (SETUP_WAIT == 0) ? S_PRG_DATA : S_PRG_WAIT;
            S_PRG_WAIT: if (wait_done) state <= S_PRG_DATA;
            S_PRG_DATA: state <= S_POLL_CMD;
            S_POLL_CMD: state <= S_POLL_RD;
            S_POLL_RD:  state <= S_POLL_SMP;
            S_POLL_SMP: begin
               if (stat_ready) begin
                  err_q <= err_q | fl_rdata[ERR_HI:ERR_LO];
                  if (is_prog && !last_byte) begin
                     idx   <= idx + 1'b1;
                     state <= S_PRG_FETCH;
                  end else begin
                     idx   <= '0;
                     state <= S_FIN_CLR;
                  end
               end else if (poll_last) begin
                  tmo_q <= 1'b1;
                  idx   <= '0;
                  state <= S_FIN_CLR;
               end else begin
                  state <= S_POLL_CMD;
               end
            end
            S_FIN_CLR: state <= S_FIN_RST;
            S_FIN_RST: state <= is_prog ? S_VER_FETCH : S_VER_RD;
            S_VER_FETCH: begin
               if (take_src) begin
                  byte_q <= src_data;
                  state  <= S_VER_RD;
               end
            end
            S_VER_RD: state <= S_VER_SMP;
            S_VER_SMP: begin
               if (fl_rdata != expect_byte)
                  vfail_q <= 1'b1;
               if (last_byte) begin
                  state <= S_DONE;
               end else begin
                  idx   <= idx + 1'b1;
                  state <= is_prog ? S_VER_FETCH : S_VER_RD;
               end
            end
            S_DONE:  state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   // Bus access decode: one access per state
   always_comb begin
      bus = '0;
      unique case (state)
         S_ERA_ARM:  bus = '{we: 1'b1, re: 1'b0, at_base: 1'b1, use_byte: 1'b0, wdata: FC_ERASE_ARM};
         S_ERA_GO:   bus = '{we: 1'b1, re: 1'b0, at_base: 1'b1, use_byte: 1'b0, wdata: FC_ERASE_GO};
         S_PRG_ARM:  bus = '{we: 1'b1, re: 1'b0, at_base: 1'b0, use_byte: 1'b0, wdata: FC_PROG_ARM};
         S_PRG_DATA: bus = '{we: 1'b1, re: 1'b0, at_base: 1'b0, use_byte: 1'b1, wdata: 8'h00};
         S_POLL_CMD: bus = '{we: 1'b1, re: 1'b0, at_base: 1'b1, use_byte: 1'b0, wdata: FC_STAT_RD};
         S_POLL_RD:  bus = '{we: 1'b0, re: 1'b1, at_base: 1'b1, use_byte: 1'b0, wdata: 8'h00};
         S_FIN_CLR:  bus = '{we: 1'b1, re: 1'b0, at_base: 1'b1, use_byte: 1'b0, wdata: FC_STAT_CLR};
         S_FIN_RST:  bus = '{we: 1'b1, re: 1'b0, at_base: 1'b1, use_byte: 1'b0, wdata: FC_READ_MODE};
         S_VER_RD:   bus = '{we: 1'b0, re: 1'b1, at_base: 1'b0, use_byte: 1'b0, wdata: 8'h00};
         default:    bus = '0;
      endcase
   end

   assign fl_we       = bus.we;
   assign fl_re       = bus.re;
   assign fl_addr     = bus.at_base ? '0 : idx;
   assign fl_wdata    = bus.use_byte ? byte_q : bus.wdata;

   assign src_ready   = (state == S_PRG_FETCH) || (state == S_VER_FETCH);
   assign src_addr    = idx;

   assign busy        = (state != S_IDLE) && (state != S_DONE);
   assign done        = (state == S_DONE);
   assign timeout     = tmo_q;
   assign verify_fail = vfail_q;
   assign err_status  = err_q;

endmodule

// File: rtl/flash_bank_seq_chk.sv
module flash_bank_seq_chk #(
   parameter int unsigned SETUP_WAIT = 125
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic timeout,
   input logic verify_fail,
   input logic fl_we,
   input logic fl_re,
   input logic wait_load
);

   // R11: write and read strobes never overlap
   assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_we && fl_re));

   // R10: done is a single-cycle pulse
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: busy is low while done is shown
   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R10: a run only begins after a start request
   assert_busy_from_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R5: timeout rises only inside a run
   assert_timeout_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout) |-> busy);

   // R7: verify failure rises only inside a run
   assert_vfail_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(verify_fail) |-> busy);

   // R3: the setup command is followed by an idle bus cycle
   generate
      if (SETUP_WAIT > 0) begin : g_gap
         assert_setup_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
            wait_load |=> (!fl_we && !fl_re));
      end
   endgenerate

endmodule

bind flash_bank_seq flash_bank_seq_chk #(.SETUP_WAIT(SETUP_WAIT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .busy        (busy),
   .done        (done),
   .timeout     (timeout),
   .verify_fail (verify_fail),
   .fl_we       (fl_we),
   .fl_re       (fl_re),
   .wait_load   (wait_load)
);

// File: tb/sim_flash_bank_seq.sv
module sim_flash_bank_seq;
   localparam int AW = 4;
   localparam int NB = 16;
   localparam int PL = 6;
   localparam int SW = 3;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n, start, op;
   logic          busy, done, timeout, verify_fail;
   logic [2:0]    err_status;
   logic [AW-1:0] src_addr, fl_addr;
   logic          src_valid, src_ready, fl_we, fl_re;
   logic [7:0]    src_data, fl_wdata;
   logic [7:0]    fl_rdata = 8'h00;

   flash_bank_seq #(.ADDR_W(AW), .POLL_LIMIT(PL), .SETUP_WAIT(SW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .busy(busy), .done(done), .timeout(timeout), .verify_fail(verify_fail),
      .err_status(err_status), .src_addr(src_addr), .src_valid(src_valid),
      .src_data(src_data), .src_ready(src_ready), .fl_addr(fl_addr),
      .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .fl_we(fl_we), .fl_re(fl_re)
   );

   // Scenario knobs
   int         busy_n = 0;
   bit         stuck_busy = 0;
   logic [2:0] inj_err = 3'b000;
   int         stuck_idx = -1;
   int         pat_sel = 0;
   bit         clr_log = 0;

   function automatic logic [7:0] pat(input int sel, input int i);
      logic [7:0] v;
      v = 8'((i * 29 + 7)) ^ 8'h5A;
      return (sel == 0) ? v : ~v;
   endfunction

   // Source stream with a stall every other cycle
   bit gate = 0;
   assign src_valid = src_ready & gate;
   assign src_data  = pat(pat_sel, int'(src_addr));

   // Flash model and bus log
   logic [7:0]    mem [NB] = '{default: 8'h00};
   bit            status_mode = 0, erase_armed = 0, prog_armed = 0;
   int            busy_left = 0;
   logic [AW-1:0] lg_a [256];
   logic [7:0]    lg_d [256];
   int            lg_c [256];
   int            n_wr = 0, n_srd = 0, n_ard = 0, n_both = 0, cyc = 0;

   always @(posedge clk) begin
      cyc  <= cyc + 1;
      gate <= ~gate;
      if (clr_log) begin
         n_wr <= 0; n_srd <= 0; n_ard <= 0; n_both <= 0;
      end else begin
         if (fl_we && fl_re) n_both <= n_both + 1;
         if (fl_we) begin
            if (n_wr < 256) begin
               lg_a[n_wr] <= fl_addr;
               lg_d[n_wr] <= fl_wdata;
               lg_c[n_wr] <= cyc;
            end
            n_wr <= n_wr + 1;
         end
         if (fl_re) begin
            if (status_mode) n_srd <= n_srd + 1;
            else             n_ard <= n_ard + 1;
         end
      end
      if (fl_we) begin
         if (prog_armed) begin
            mem[fl_addr] <= mem[fl_addr] & fl_wdata;
            prog_armed   <= 0;
            busy_left    <= busy_n;
            status_mode  <= 1;
         end else begin
            case (fl_wdata)
               8'h20: erase_armed <= 1;
               8'hD0: if (erase_armed) begin
                  for (int i = 0; i < NB; i++)
                     mem[i] <= (i == stuck_idx) ? 8'hF7 : 8'hFF;
                  erase_armed <= 0;
                  busy_left   <= busy_n;
                  status_mode <= 1;
               end
               8'h70: status_mode <= 1;
               8'h40: prog_armed <= 1;
               8'hFF: begin status_mode <= 0; erase_armed <= 0; end
               default: ;
            endcase
         end
      end
      if (fl_re) begin
         if (status_mode) begin
            fl_rdata <= {(!stuck_busy && busy_left == 0), 1'b0, inj_err, 3'b000};
            if (busy_left > 0) busy_left <= busy_left - 1;
         end else begin
            fl_rdata <= mem[fl_addr];
         end
      end
   end

   // Checking
   int n_chk = 0, n_err = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   logic [AW-1:0] e_a [256];
   logic [7:0]    e_d [256];
   int            n_exp;

   task automatic push(input int a, input int d);
      e_a[n_exp] = AW'(a);
      e_d[n_exp] = 8'(d);
      n_exp++;
   endtask

   task automatic build_erase(input int reads);
      n_exp = 0;
      push(0, 'h20); push(0, 'hD0);
      for (int r = 0; r < reads; r++) push(0, 'h70);
      push(0, 'h50); push(0, 'hFF);
   endtask

   task automatic build_prog(input int nbytes, input int reads, input int last_reads);
      n_exp = 0;
      for (int i = 0; i < nbytes; i++) begin
         push(i, 'h40); push(i, pat(pat_sel, i));
         for (int r = 0; r < ((i == nbytes - 1) ? last_reads : reads); r++) push(0, 'h70);
      end
      push(0, 'h50); push(0, 'hFF);
   endtask

   function automatic int log_mismatch();
      int bad = (n_wr != n_exp) ? 1 : 0;
      for (int k = 0; k < n_exp && k < n_wr; k++)
         if (lg_a[k] !== e_a[k] || lg_d[k] !== e_d[k]) bad++;
      return bad;
   endfunction

   task automatic run(input logic o);
      int w;
      @(negedge clk) clr_log = 1;
      @(negedge clk) begin clr_log = 0; start = 1; op = o; end
      @(negedge clk) start = 0;
      chk(busy === 1'b1, "R10", "busy after start", int'(busy), 1);
      w = 0;
      while (done !== 1'b1 && w < 20000) begin @(negedge clk); w++; end
      chk(done === 1'b1 && busy === 1'b0, "R10", "done with busy low", int'(busy), 0);
      @(negedge clk);
      chk(done === 1'b0, "R10", "done single cycle", int'(done), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      bit exp_fail;
      rst_n = 0; start = 0; op = 0;
      repeat (3) @(negedge clk);
      // R12 reset state
      chk(busy === 0 && done === 0, "R12", "busy/done at reset", int'(busy), 0);
      chk(fl_we === 0 && fl_re === 0 && src_ready === 0, "R12", "strobes at reset", int'(fl_we), 0);
      chk(timeout === 0 && verify_fail === 0 && err_status === 3'b000, "R12", "flags at reset",
          int'(err_status), 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // Plain erase, two busy reads
      busy_n = 2;
      run(1'b0);
      build_erase(3);
      chk(log_mismatch() == 0, "R1", "erase write sequence", log_mismatch(), 0);
      chk(n_srd == 3, "R2", "status reads", n_srd, 3);
      chk(lg_d[n_wr-2] == 8'h50 && lg_d[n_wr-1] == 8'hFF, "R4", "closing writes",
          int'(lg_d[n_wr-1]), 'hFF);
      chk(timeout === 0, "R5", "no timeout", int'(timeout), 0);
      chk(verify_fail === 0, "R7", "clean erase verify", int'(verify_fail), 0);
      chk(n_ard == NB, "R7", "array reads", n_ard, NB);
      chk(err_status === 3'b000, "R9", "no error bits", int'(err_status), 0);
      chk(n_both == 0, "R11", "overlapping strobes", n_both, 0);

      // Erase with a bit that cannot be erased
      stuck_idx = 5;
      run(1'b0);
      chk(verify_fail === 1, "R7", "stuck bit detected", int'(verify_fail), 1);
      stuck_idx = -1;

      // Ready on the last permitted read
      busy_n = PL - 1;
      run(1'b0);
      chk(timeout === 0, "R5", "ready on last read", int'(timeout), 0);
      chk(n_srd == PL, "R5", "reads at boundary", n_srd, PL);

      // Device never ready
      stuck_busy = 1;
      run(1'b0);
      chk(timeout === 1, "R5", "stuck device timeout", int'(timeout), 1);
      chk(n_srd == PL, "R5", "reads before timeout", n_srd, PL);
      build_erase(PL);
      chk(log_mismatch() == 0, "R4", "recovery after timeout", log_mismatch(), 0);
      chk(n_ard == NB, "R7", "verify after timeout", n_ard, NB);
      stuck_busy = 0;

      // Error bits captured, then cleared by next start
      busy_n = 0; inj_err = 3'b101;
      run(1'b0);
      chk(err_status === 3'b101, "R9", "error bits captured", int'(err_status), 5);
      chk(timeout === 0, "R10", "timeout cleared at start", int'(timeout), 0);
      inj_err = 3'b000;
      run(1'b0);
      chk(err_status === 3'b000, "R10", "error bits cleared", int'(err_status), 0);

      // Program over an erased bank
      busy_n = 1; pat_sel = 0;
      run(1'b1);
      build_prog(NB, 2, 2);
      chk(log_mismatch() == 0, "R3", "program write sequence", log_mismatch(), 0);
      begin
         int gap_bad = 0;
         for (int i = 0; i < NB; i++)
            if (lg_c[i*4+1] - lg_c[i*4] != SW + 1) gap_bad++;
         chk(gap_bad == 0, "R3", "setup wait gaps", gap_bad, 0);
      end
      chk(n_srd == NB * 2, "R2", "program status reads", n_srd, NB * 2);
      chk(verify_fail === 0, "R8", "program verify pass", int'(verify_fail), 0);
      chk(n_ard == NB, "R8", "program verify reads", n_ard, NB);

      // Same data again: no false failure
      run(1'b1);
      chk(verify_fail === 0, "R8", "rewrite same data", int'(verify_fail), 0);

      // Inverted data over unerased bank
      pat_sel = 1;
      exp_fail = 0;
      for (int i = 0; i < NB; i++)
         if ((pat(0, i) & pat(1, i)) != pat(1, i)) exp_fail = 1;
      run(1'b1);
      chk(verify_fail === exp_fail, "R8", "program over old data", int'(verify_fail), int'(exp_fail));

      // Timeout during program stops the loop
      pat_sel = 0; busy_n = 0;
      run(1'b0);
      stuck_busy = 1;
      run(1'b1);
      build_prog(1, PL, PL);
      chk(log_mismatch() == 0, "R6", "byte loop stopped", log_mismatch(), 0);
      chk(timeout === 1, "R5", "program timeout", int'(timeout), 1);
      exp_fail = 0;
      for (int i = 1; i < NB; i++)
         if (pat(0, i) != 8'hFF) exp_fail = 1;
      chk(verify_fail === exp_fail, "R6", "untouched bytes verify", int'(verify_fail), int'(exp_fail));
      stuck_busy = 0;
      chk(n_both == 0, "R11", "overlapping strobes", n_both, 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule